// File: doc/BRIEF.md
# Bidirectional DSP Logical Shifter

This unit performs a single-cycle logical shift on the upper word of a 40-bit DSP register. A 40-bit register here is made up of 8 guard bits (39:32), a 16-bit upper word (31:16) and a 16-bit lower word (15:0). Only the upper word of the first source is shifted. The guard and lower parts of the result are always zero. A signed 6-bit count selects the direction and the distance: positive counts shift left and negative counts shift right. The count comes either from a register operand or from an immediate.

Operations arrive on a valid/ready input. Each accepted operation produces one result in a single output register, which also has a valid/ready handshake. The input is ready whenever that register is empty or is being drained in the same cycle. While the output is stalled, the result stays held and no new operation is taken.

Alongside the data path, the unit keeps a five-bit status word (DC, N, Z, V, GT). Unconditional operations update this word from each result. Conditionally executed operations write their result but leave the status word unchanged. A 3-bit condition-select input chooses what DC reports.

Top module: `dsp_lshift_unit`

## Requirements
- R1: Bits 39:32 and 15:0 of `src1_data` have no effect on any output; only bits 31:16 are shifted.
- R2: Whenever `out_valid` is 1, `out_data[39:32]` and `out_data[15:0]` are zero.
- R3: The count is the signed 6-bit value `imm_count` when `use_imm`=1, and otherwise `src2_data[21:16]`. No other bit of `src2_data` has any effect.
- R4: A count c in 1..15 gives upper word = (src upper << c) mod 2^16. A count -c with c in 1..15 gives upper word = src upper >> c. Vacated bits are zero in both directions, and a count of 0 passes the word through unchanged.
- R5: Counts of +16 and -16 give an all-zero upper word. For counts outside -16..+16 the upper word is unspecified, but the guard and lower bits are still zero and no output bit is unknown.
- R6: `status_flags` is {DC, N, Z, V, GT}, with DC at bit 4 and GT at bit 0. After an unconditional operation (`cond_exec`=0) is accepted, the flags hold N = result bit 31, Z = (result bits 31:16 all zero), V = 0 and GT = !N && !Z. The new flags appear in the same cycle as that result.
- R7: An operation accepted with `cond_exec`=1 writes its result but leaves `status_flags` unchanged.
- R8: DC depends on the `cs_sel` value captured with the operation: 0 gives the carry (the last bit shifted out, 0 for a count of 0), 1 gives N, 2 gives Z, 3 gives V, 4 gives GT, 5 gives !N, and 6 or 7 give 0. The last bit out is original bit 31-c+1 of the register for a left shift by c, and original bit 16+c-1 for a right shift by c.
- R9: `out_illegal` is 1 with a result exactly when its operation had `use_imm`=1 and `src1_idx` differed from `dst_idx`.
- R10: After reset, `out_valid`=0 and `status_flags`=0. `in_ready` = !`out_valid` || `out_ready`. A result appears on the edge that accepts its operation and is held unchanged while `out_valid` && !`out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts the offered operation this cycle |
| src1_data | input | 40 | First source register value |
| src2_data | input | 40 | Second source register value (count in bits 21:16) |
| imm_count | input | 6 | Immediate signed count |
| use_imm | input | 1 | Take the count from `imm_count` |
| src1_idx | input | 3 | Register index of the first source |
| dst_idx | input | 3 | Register index of the destination |
| cond_exec | input | 1 | Operation is conditionally executed (flags untouched) |
| cs_sel | input | 3 | DC meaning select |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 40 | Destination value |
| out_illegal | output | 1 | Immediate form with mismatched source and destination |
| status_flags | output | 5 | {DC, N, Z, V, GT} |

## Verification
The bench aims at the carry on a shift of zero and at the carry at full reach (±16). A design that drops the zero special case would report a stale bit, and a design that picks the wrong end would report the neighbouring bit. It fills the guard and lower fields of both sources with junk, which catches designs that leak those bits into the result or that read the count from the wrong field. Conditional operations are placed between unconditional ones to expose flags that are overwritten when they should be held. A random stall pattern on `out_ready` shows any design that overwrites or drops a result while it is held.

// File: rtl/dsp_lshift_pkg.sv
package dsp_lshift_pkg;
  localparam int GUARD_W = 8;
  localparam int HALF_W  = 16;
  localparam int CNT_W   = 6;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } shflags_t;

  typedef enum logic [2:0] {
    DCM_CARRY = 3'd0,
    DCM_NEG   = 3'd1,
    DCM_ZERO  = 3'd2,
    DCM_OVF   = 3'd3,
    DCM_GT    = 3'd4,
    DCM_GE    = 3'd5,
    DCM_RSV6  = 3'd6,
    DCM_RSV7  = 3'd7
  } dc_mode_t;
endpackage

// File: rtl/lshift_core.sv
module lshift_core #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic [HALF_W-1:0] word_in,
  input  logic [CNT_W-1:0]  count,
  output logic [HALF_W-1:0] word_out,
  output logic              last_out
);
  // wide enough for the largest encodable shift in either direction
  localparam int WIDE_W = 2*HALF_W + (1 << (CNT_W-1));

  logic              go_right;
  logic [CNT_W:0]    mag_right;
  logic [WIDE_W-1:0] left_w;
  logic [WIDE_W-1:0] right_w;

  assign go_right  = count[CNT_W-1];
  assign mag_right = (CNT_W+1)'(0) - {count[CNT_W-1], count};

  always_comb begin
    left_w  = WIDE_W'(word_in) << count;
    right_w = {word_in, (WIDE_W-HALF_W)'(0)} >> mag_right;
    if (go_right) begin
      word_out = right_w[WIDE_W-1 -: HALF_W];
      last_out = right_w[WIDE_W-HALF_W-1];
    end else begin
      word_out = left_w[HALF_W-1:0];
      last_out = (count == '0) ? 1'b0 : left_w[HALF_W];
    end
  end
endmodule

// File: rtl/lshift_flags.sv
module lshift_flags
  import dsp_lshift_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] word,
  input  logic              carry,
  input  logic [2:0]        sel,
  output shflags_t          flags
);
  logic neg, zer, gt;

  assign neg = word[HALF_W-1];
  assign zer = (word == '0);
  assign gt  = !neg && !zer;

  always_comb begin
    flags.n  = neg;
    flags.z  = zer;
    flags.v  = 1'b0;
    flags.gt = gt;
    unique case (dc_mode_t'(sel))
      DCM_CARRY: flags.dc = carry;
      DCM_NEG:   flags.dc = neg;
      DCM_ZERO:  flags.dc = zer;
      DCM_OVF:   flags.dc = 1'b0;
      DCM_GT:    flags.dc = gt;
      DCM_GE:    flags.dc = !neg;
      default:   flags.dc = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_lshift_unit.sv
module dsp_lshift_unit
  import dsp_lshift_pkg::*;
#(
  parameter int GUARD_BITS = dsp_lshift_pkg::GUARD_W,
  parameter int WORD_BITS  = dsp_lshift_pkg::HALF_W,
  parameter int COUNT_BITS = dsp_lshift_pkg::CNT_W,
  parameter int IDX_BITS   = 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [GUARD_BITS+2*WORD_BITS-1:0]        src1_data,
  input  logic [GUARD_BITS+2*WORD_BITS-1:0]        src2_data,
  input  logic [COUNT_BITS-1:0]                    imm_count,
  input  logic                                     use_imm,
  input  logic [IDX_BITS-1:0]                      src1_idx,
  input  logic [IDX_BITS-1:0]                      dst_idx,
  input  logic                                     cond_exec,
  input  logic [2:0]                               cs_sel,
  output logic                                     out_valid,
  input  logic                                     out_ready,
  output logic [GUARD_BITS+2*WORD_BITS-1:0]        out_data,
  output logic                                     out_illegal,
  output logic [4:0]                               status_flags
);
  localparam int REG_BITS = GUARD_BITS + 2*WORD_BITS;
  localparam int UP_LSB   = WORD_BITS;
  localparam int CNT_LSB  = WORD_BITS;

  logic [WORD_BITS-1:0]  upper_in;
  logic [COUNT_BITS-1:0] count_sel;
  logic [WORD_BITS-1:0]  upper_out;
  logic                  shifted_out;
  shflags_t              flags_next;
  shflags_t              flags_q;
  logic                  accept;
  logic                  unused_bits;

  assign upper_in  = src1_data[UP_LSB +: WORD_BITS];
  assign count_sel = use_imm ? imm_count : src2_data[CNT_LSB +: COUNT_BITS];
  assign unused_bits = ^{src1_data[REG_BITS-1:UP_LSB+WORD_BITS], src1_data[UP_LSB-1:0],
                         src2_data[REG_BITS-1:CNT_LSB+COUNT_BITS], src2_data[CNT_LSB-1:0]};

  lshift_core #(.HALF_W(WORD_BITS), .CNT_W(COUNT_BITS)) core_i (
    .word_in (upper_in),
    .count   (count_sel),
    .word_out(upper_out),
    .last_out(shifted_out)
  );

  lshift_flags #(.HALF_W(WORD_BITS)) flg_i (
    .word (upper_out),
    .carry(shifted_out),
    .sel  (cs_sel),
    .flags(flags_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
      flags_q     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= {(GUARD_BITS)'(0), upper_out, (WORD_BITS)'(0)};
      out_illegal <= use_imm && (src1_idx != dst_idx);
      if (!cond_exec) flags_q <= flags_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign status_flags = flags_q;

  // R2
  guard_lower_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[REG_BITS-1:UP_LSB+WORD_BITS] == '0) && (out_data[UP_LSB-1:0] == '0));

  // R7
  cond_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cond_exec) |=> $stable(status_flags));

  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_flags[1]);

  // R6
  gt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[0] |-> (!status_flags[3] && !status_flags[2]));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  // R4
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && count_sel == '0) |=> (out_data[UP_LSB +: WORD_BITS] == $past(src1_data[UP_LSB +: WORD_BITS])));
endmodule

// File: tb/dsp_lshift_unit_tb.sv
module dsp_lshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] src1_data = '0;
  logic [39:0] src2_data = '0;
  logic [5:0]  imm_count = '0;
  logic        use_imm = 1'b0;
  logic [2:0]  src1_idx = '0;
  logic [2:0]  dst_idx = '0;
  logic        cond_exec = 1'b0;
  logic [2:0]  cs_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [39:0] out_data;
  logic        out_illegal;
  logic [4:0]  status_flags;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference state
  bit          m_valid = 0;
  logic [39:0] m_data = '0;
  bit          m_ill = 0;
  bit [4:0]    m_flags = '0;
  bit          m_unspec = 0;

  always #5 clk = ~clk;

  dsp_lshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src1_data(src1_data), .src2_data(src2_data), .imm_count(imm_count),
    .use_imm(use_imm), .src1_idx(src1_idx), .dst_idx(dst_idx),
    .cond_exec(cond_exec), .cs_sel(cs_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal),
    .status_flags(status_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s) t=%0t: actual %h expected %h", req, cur_req, $time, act, exp);
    end
  endtask

  // behavioural model of one operation
  task automatic model_op();
    int c;
    bit [15:0] w;
    bit co, n, z, gt, dc;
    c = $signed(use_imm ? imm_count : src2_data[21:16]);
    w = src1_data[31:16];
    co = 0;
    if (c >= 0) begin
      for (int k = 0; k < c; k++) begin co = w[15]; w = w << 1; end
    end else begin
      for (int k = 0; k < -c; k++) begin co = w[0]; w = w >> 1; end
    end
    m_unspec = (c > 16) || (c < -16);
    m_data = {8'h00, w, 16'h0000};
    m_ill  = use_imm && (src1_idx != dst_idx);
    n = w[15]; z = (w == 0); gt = !n && !z;
    case (cs_sel)
      3'd0: dc = co;
      3'd1: dc = n;
      3'd2: dc = z;
      3'd3: dc = 0;
      3'd4: dc = gt;
      3'd5: dc = !n;
      default: dc = 0;
    endcase
    if (!cond_exec) m_flags = {dc, n, z, 1'b0, gt};
    m_valid = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_flags = '0; m_unspec = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      model_op();
    end else if (out_ready) begin
      m_valid = 0;
    end
    if (cyc > 60000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired (%s)", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid === 1'b0, "R10", 64'(out_valid), 0);
      chk(status_flags === 5'd0, "R10", 64'(status_flags), 0);
    end else begin
      chk(out_valid === m_valid, "R10", 64'(out_valid), 64'(m_valid));
      chk(in_ready === (!m_valid || out_ready), "R10", 64'(in_ready), 64'(!m_valid || out_ready));
      chk(status_flags === m_flags, "R6", 64'(status_flags), 64'(m_flags));
      if (m_valid) begin
        if (m_unspec)
          chk(!$isunknown(out_data) && out_data[39:32] == 0 && out_data[15:0] == 0, "R5",
              64'(out_data), 64'(m_data));
        else
          chk(out_data === m_data, "R4", 64'(out_data), 64'(m_data));
        chk(out_illegal === m_ill, "R9", 64'(out_illegal), 64'(m_ill));
      end
    end
  end

  task automatic send(input logic [39:0] a, input logic [39:0] b, input int cnt, input bit imm,
                      input bit cnd, input logic [2:0] cs, input logic [2:0] si, input logic [2:0] di);
    bit ok;
    @(negedge clk); #2;
    src1_data = a; src2_data = b; use_imm = imm; cond_exec = cnd; cs_sel = cs;
    src1_idx = si; dst_idx = di; in_valid = 1;
    if (imm) imm_count = 6'(cnt); else src2_data[21:16] = 6'(cnt);
    forever begin
      out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk); #2;
    end
    @(negedge clk); #2;
    in_valid = 0;
    out_ready = stall_mode ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic drain();
    @(negedge clk); #2; out_ready = 1; in_valid = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    void'($urandom(17));
    repeat (3) @(posedge clk);
    @(negedge clk); #2; rst_n = 1;

    // R1: junk in guard and lower fields of source 1
    cur_req = "R1";
    send(40'hFF_A5C3_FFFF, 40'h0, 3, 0, 0, 0, 1, 1);
    send(40'h00_A5C3_0000, 40'h0, 3, 0, 0, 0, 1, 1);
    send(40'h5A_1234_9876, 40'h0, -5, 0, 0, 0, 2, 2);

    // R3: count source, junk around the count field
    cur_req = "R3";
    send(40'h00_8001_0000, 40'hFF_FFC0_FFFF, 2, 0, 0, 0, 0, 0);
    send(40'h00_8001_0000, 40'hFF_FFFF_FFFF, 4, 1, 0, 0, 3, 3);
    send(40'h00_8001_0000, 40'h00_0004_0000, -1, 1, 0, 0, 5, 5);

    // R4: directed directions and zero
    cur_req = "R4";
    send(40'h00_FFFF_0000, 0, 1, 0, 0, 0, 0, 0);
    send(40'h00_FFFF_0000, 0, -1, 0, 0, 0, 0, 0);
    send(40'h00_8000_0000, 0, 15, 0, 0, 0, 0, 0);
    send(40'h00_8000_0000, 0, -15, 0, 0, 0, 0, 0);
    send(40'h00_C001_0000, 0, 0, 0, 0, 0, 0, 0);

    // R5: full reach and out-of-range (conditional so flags stay defined)
    cur_req = "R5";
    send(40'h00_FFFF_0000, 0, 16, 0, 0, 0, 0, 0);
    send(40'h00_FFFF_0000, 0, -16, 0, 0, 0, 0, 0);
    send(40'h00_0001_0000, 0, 16, 0, 0, 0, 0, 0);
    send(40'h00_8000_0000, 0, -16, 0, 0, 0, 0, 0);
    send(40'h00_FFFF_0000, 0, 31, 0, 1, 0, 0, 0);
    send(40'h00_FFFF_0000, 0, -32, 0, 1, 0, 0, 0);
    send(40'h00_FFFF_0000, 0, 20, 1, 1, 0, 4, 4);

    // R7: conditional ops between unconditional ones
    cur_req = "R7";
    send(40'h00_0001_0000, 0, 1, 0, 0, 0, 0, 0);
    send(40'h00_0000_0000, 0, 3, 0, 1, 2, 0, 0);
    send(40'h00_8000_0000, 0, 0, 0, 1, 1, 0, 0);
    send(40'h00_0000_0000, 0, 0, 0, 0, 2, 0, 0);

    // R8: every DC selector over a few shifts
    cur_req = "R8";
    for (int s = 0; s < 8; s++) begin
      send(40'h00_8001_0000, 0, 1, 0, 0, 3'(s), 0, 0);
      send(40'h00_8001_0000, 0, -1, 0, 0, 3'(s), 0, 0);
      send(40'h00_0000_0000, 0, 0, 0, 0, 3'(s), 0, 0);
      send(40'h00_4000_0000, 0, 2, 0, 0, 3'(s), 0, 0);
    end

    // R9: immediate form with matched and mismatched indices
    cur_req = "R9";
    send(40'h00_1234_0000, 0, 2, 1, 0, 0, 3, 3);
    send(40'h00_1234_0000, 0, 2, 1, 0, 0, 3, 4);
    send(40'h00_1234_0000, 0, 2, 0, 0, 0, 3, 4);

    // R10: random traffic under back-pressure; also R2 R6
    cur_req = "R10";
    stall_mode = 1;
    for (int i = 0; i < 300; i++) begin
      int c;
      bit cn;
      c  = int'($urandom_range(32)) - 16;
      cn = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) begin c = c * 2; cn = 1; end
      send({$urandom, $urandom} & 40'hFF_FFFF_FFFF, {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
           c, 1'($urandom % 2), cn, 3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8));
    end
    stall_mode = 0;
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule